// File: doc/BRIEF.md
# Row Redundancy Repair Decoder

This block turns a row address into word line enables for a memory sub-array that carries spare rows next to its normal rows. A small bank of repair entries, each holding a valid bit and the address of a faulty row, stands in for a fuse bank. The entries are loaded through a programming port before the array is used. After that they keep their values.

On every access, the incoming row address is compared with all repair entries in the same cycle. On a match, the spare word line that belongs to the matching entry is raised and the normal decoder is gated off. Without a match, the normal one-hot decoder drives the addressed row. The word line vectors and a hit flag are registered and appear one clock after the address.

A two-state controller tracks whether an access is being served. ST_IDLE moves to ST_ACTIVE when the access enable is sampled high (transition "start"). ST_ACTIVE stays there while the enable remains high ("continue") and returns to ST_IDLE when it drops ("finish"). ST_IDLE stays idle while the enable is low ("wait"). Programming writes are taken only in cycles where the access enable is low.

Top module: `rr_repair_decoder`

## Requirements
- R1: While reset is held, and after its release, every word line output and the hit flag are 0, and every repair entry is invalid. An access right after reset therefore decodes normally.
- R2: When an access enable is sampled high and no valid entry matches, exactly bit `row_addr` of `wl_norm` is 1 on the next cycle, with `wl_spare` zero and `spare_hit` 0.
- R3: When an access matches the valid entry at index i, on the next cycle `wl_spare` has only bit i set, `wl_norm` is all zero, and `spare_hit` is 1.
- R4: An entry whose valid bit is 0 never matches, whatever address it holds.
- R5: When several valid entries hold the same address, only the entry with the lowest index raises its spare line, so at most one bit of `wl_spare` is ever 1.
- R6: When the access enable is sampled low, all normal and spare word lines and `spare_hit` are 0 on the next cycle.
- R7: A programming write (`prog_we`=1) in a cycle where `acc_en` is 1 leaves every repair entry unchanged.
- R8: A programming write with `acc_en` low sets entry `prog_idx` to (`prog_valid`, `prog_addr`). The entry holds that value until the next accepted write to the same index, and the new value replaces the old one.
- R9: The outputs are registered. A new address changes the outputs only at the next rising clock edge, and the hit flag is aligned with the word lines of the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access enable; high means the address is served this cycle |
| row_addr | input | 7 | Row address of the access |
| prog_we | input | 1 | Write strobe for a repair entry |
| prog_idx | input | 2 | Index of the repair entry to write |
| prog_valid | input | 1 | Valid bit written into the entry |
| prog_addr | input | 7 | Faulty row address written into the entry |
| wl_norm | output | 128 | Normal word line enables, one-hot or zero |
| wl_spare | output | 4 | Spare word line enables, bit i belongs to entry i |
| spare_hit | output | 1 | A spare row replaced the addressed row |

## Verification
Every result of an access is due exactly one rising edge after the address and enable are driven. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a period after the edge that loads them. A programming write takes effect at the edge where it is sampled, so it is observed through an access in a later cycle. One directed check reads the outputs just before the edge, to confirm that a new address has not yet reached them.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } rr_state_e;
endpackage

// File: rtl/rr_fuse_bank.sv
module rr_fuse_bank #(
    parameter int ROW_W   = 7,
    parameter int N_SPARE = 4,
    parameter int IDX_W   = (N_SPARE > 1) ? $clog2(N_SPARE) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_valid,
    input  logic [ROW_W-1:0]           wr_addr,
    output logic [N_SPARE-1:0]         ent_valid,
    output logic [N_SPARE*ROW_W-1:0]   ent_addr
);
    // one register pair per repair entry; stands in for a fuse row
    for (genvar g = 0; g < N_SPARE; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g]                 <= 1'b0;
                ent_addr[g*ROW_W +: ROW_W]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_valid[g]                 <= wr_valid;
                ent_addr[g*ROW_W +: ROW_W]   <= wr_addr;
            end
        end
    end

    // R7
    entries_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> ($stable(ent_valid) && $stable(ent_addr)));
endmodule

// File: rtl/rr_match.sv
module rr_match #(
    parameter int ROW_W   = 7,
    parameter int N_SPARE = 4
) (
    input  logic [ROW_W-1:0]           addr,
    input  logic [N_SPARE-1:0]         ent_valid,
    input  logic [N_SPARE*ROW_W-1:0]   ent_addr,
    output logic [N_SPARE-1:0]         sel,
    output logic                       any
);
    logic [N_SPARE-1:0] eq;

    // one equality comparator per spare line
    for (genvar g = 0; g < N_SPARE; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_addr[g*ROW_W +: ROW_W] == addr);
    end

    // lowest index wins on duplicates
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = 0; i < N_SPARE; i++) begin
            if (eq[i] && !any) begin
                sel[i] = 1'b1;
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_row_dec.sv
module rr_row_dec #(
    parameter int ROW_W  = 7,
    parameter int N_ROWS = 1 << ROW_W
) (
    input  logic              en,
    input  logic [ROW_W-1:0]  addr,
    output logic [N_ROWS-1:0] wl
);
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign wl[r] = en && (addr == ROW_W'(r));
    end
endmodule

// File: rtl/rr_repair_decoder.sv
module rr_repair_decoder #(
    parameter int ROW_W   = 7,
    parameter int N_SPARE = 4,
    parameter int N_ROWS  = 1 << ROW_W,
    parameter int IDX_W   = (N_SPARE > 1) ? $clog2(N_SPARE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic [ROW_W-1:0]   row_addr,
    input  logic               prog_we,
    input  logic [IDX_W-1:0]   prog_idx,
    input  logic               prog_valid,
    input  logic [ROW_W-1:0]   prog_addr,
    output logic [N_ROWS-1:0]  wl_norm,
    output logic [N_SPARE-1:0] wl_spare,
    output logic               spare_hit
);
    import rr_pkg::*;

    rr_state_e state_q, state_d;

    logic [N_SPARE-1:0]       ent_valid;
    logic [N_SPARE*ROW_W-1:0] ent_addr;
    logic [N_SPARE-1:0]       sel;
    logic                     any_hit;
    logic [N_ROWS-1:0]        norm_d;
    logic                     wr_ok;

    // writes only outside an access
    assign wr_ok = prog_we && !acc_en;

    rr_fuse_bank #(.ROW_W(ROW_W), .N_SPARE(N_SPARE), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .wr_en     (wr_ok),
        .wr_idx    (prog_idx),
        .wr_valid  (prog_valid),
        .wr_addr   (prog_addr),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr)
    );

    rr_match #(.ROW_W(ROW_W), .N_SPARE(N_SPARE)) u_match (
        .addr      (row_addr),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .sel       (sel),
        .any       (any_hit)
    );

    rr_row_dec #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_dec (
        .en   (acc_en && !any_hit),
        .addr (row_addr),
        .wl   (norm_d)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = acc_en ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: state_d = acc_en ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wl_norm   <= '0;
            wl_spare  <= '0;
            spare_hit <= 1'b0;
        end else if (acc_en) begin
            wl_norm   <= norm_d;
            wl_spare  <= sel;
            spare_hit <= any_hit;
        end else begin
            wl_norm   <= '0;
            wl_spare  <= '0;
            spare_hit <= 1'b0;
        end
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (wl_norm == '0 && wl_spare == '0 && !spare_hit));

    // R2
    normal_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !spare_hit) |-> $onehot(wl_norm));

    // R3
    hit_gates_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_hit |-> (wl_norm == '0 && $onehot(wl_spare)));

    // R5
    single_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl_spare) && (spare_hit == (wl_spare != '0)));
endmodule

// File: tb/sim_rr_repair_decoder.sv
module sim_rr_repair_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_en = 1'b0;
    logic [6:0]   row_addr = '0;
    logic         prog_we = 1'b0;
    logic [1:0]   prog_idx = '0;
    logic         prog_valid = 1'b0;
    logic [6:0]   prog_addr = '0;
    logic [127:0] wl_norm;
    logic [3:0]   wl_spare;
    logic         spare_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_repair_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .row_addr(row_addr),
        .prog_we(prog_we), .prog_idx(prog_idx), .prog_valid(prog_valid),
        .prog_addr(prog_addr), .wl_norm(wl_norm), .wl_spare(wl_spare),
        .spare_hit(spare_hit)
    );

    // {addr, expected spare index; 7 = no spare}
    localparam logic [9:0] VEC [8] = '{
        {7'd10, 3'd0}, {7'd127, 3'd1}, {7'd0, 3'd2}, {7'd9, 3'd7},
        {7'd11, 3'd7}, {7'd64, 3'd7}, {7'd126, 3'd7}, {7'd1, 3'd7}
    };

    // sp < 0 and addr < 0: all quiet; sp < 0: normal row; else spare sp
    function automatic logic [132:0] expv(input int sp, input int addr);
        logic [132:0] v;
        v = '0;
        if (sp >= 0) begin
            v[132] = 1'b1;
            v[128 + sp] = 1'b1;
        end else if (addr >= 0) begin
            v[addr] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [132:0] exp);
        logic [132:0] act;
        act = {spare_hit, wl_spare, wl_norm};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic prog(input int idx, input bit v, input int addr);
        @(negedge clk);
        acc_en = 1'b0; prog_we = 1'b1; prog_idx = 2'(idx);
        prog_valid = v; prog_addr = 7'(addr);
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic access(input int addr, input int sp, input string tag);
        acc_en = 1'b1; row_addr = 7'(addr);
        @(negedge clk);
        check(tag, expv(sp, addr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs during reset", expv(-1, -1));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", expv(-1, -1));
        access(10, -1, "R1 entries invalid after reset");

        prog(0, 1'b1, 10);
        prog(1, 1'b1, 127);
        prog(2, 1'b1, 0);
        prog(3, 1'b0, 55);

        for (int i = 0; i < 8; i++) begin
            int a, s;
            a = int'(VEC[i][9:3]);
            s = (VEC[i][2:0] == 3'd7) ? -1 : int'(VEC[i][2:0]);
            access(a, s, (s < 0) ? "R2 normal row" : "R3 spare row");
        end

        access(55, -1, "R4 invalid entry ignored");

        // R6: enable low with a repaired address
        acc_en = 1'b0; row_addr = 7'd10;
        @(negedge clk);
        check("R6 enable low quiet", expv(-1, -1));

        // R9: new address not visible before the edge
        access(20, -1, "R9 setup row 20");
        acc_en = 1'b1; row_addr = 7'd127;
        @(posedge clk);
        #1 ;
        @(negedge clk);
        check("R9 spare after one edge", expv(1, 127));
        row_addr = 7'd30;
        #1 check("R9 no change before edge", expv(1, 127));
        @(negedge clk);
        check("R9 row 30 after edge", expv(-1, 30));

        // R7: write during access is dropped
        acc_en = 1'b1; row_addr = 7'd20;
        prog_we = 1'b1; prog_idx = 2'd3; prog_valid = 1'b1; prog_addr = 7'd20;
        @(negedge clk);
        prog_we = 1'b0;
        check("R7 same cycle normal", expv(-1, 20));
        access(20, -1, "R7 write ignored");

        // R5: duplicate address, lowest index wins
        prog(3, 1'b1, 10);
        access(10, 0, "R5 lowest index wins");

        // R8: rewrite entry 0
        prog(0, 1'b1, 30);
        access(10, 3, "R8 old address now on entry 3");
        access(30, 0, "R8 new address on entry 0");
        access(55, -1, "R8 other rows normal");

        acc_en = 1'b0;
        @(negedge clk);
        check("R6 return idle", expv(-1, -1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule